// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block keeps the two thresholds used by a FIFO's partial-status flags: the empty-side offset `n` and the full-side offset `m`. Each offset is split into a low part of eight bits and a high part that carries the remaining bits needed to span the FIFO depth. That gives four small registers in all. They are written from the shared input data bus on the write clock and read back onto a dedicated data output on the read clock. The offsets go straight to the FIFO's flag logic.

A single active-low select input chooses between normal FIFO traffic and offset access. The block decides at reset whether offset access exists at all. If the select input is low during reset, the block is in programmable mode. If it is high, the select input behaves only as a second write enable, and the offsets keep their reset values.

Every offset write or offset read steps a cyclic position in this order: empty-low, empty-high, full-low, full-high, and then back to empty-low. Writes and reads keep separate positions. Each position is kept while the select input is high, so a caller can update only some of the registers and later carry on from the next one.

Top module: `fifo_ofs_prog`

## Requirements
- R1: `prog_mode` becomes 1 when `offset_sel_n` is 0 at a `wclk` edge with `rst_n` low, and 0 when it is 1. It holds that value for as long as `rst_n` stays high.
- R2: A `wclk` edge with `rst_n` low has three effects. Both offsets become 7, made of low part 7 and high part 0. The write position returns to empty-low. An `rclk` edge with `rst_n` low has two effects. The read position returns to empty-low, and `cfg_rdata` and `cfg_rd_valid` clear to 0.
- R3: In programmable mode, a `wclk` edge with `offset_sel_n`=0 and `wr_en_n`=0 stores the bus value at the current write position. Positions 0 and 2 (empty-low, full-low) take `din[7:0]` into offset bits [7:0]. Positions 1 and 3 (empty-high, full-high) take `din[HI_W-1:0]` into offset bits [OFS_W-1:8]. The position then advances by one and wraps from 3 to 0.
- R4: A `wclk` edge with `offset_sel_n`=0 and `wr_en_n`=1 changes neither offset nor the write position.
- R5: `fifo_wr` is 1 exactly when `offset_sel_n`=1 and `wr_en_n`=0, in either mode. Such a cycle leaves the offsets and the write position unchanged.
- R6: Raising `offset_sel_n` between offset accesses keeps both positions. The next offset access uses the register after the last one touched.
- R7: In programmable mode, an `rclk` edge with `offset_sel_n`=0 and both `rd_en0_n` and `rd_en1_n` at 0 does three things. It loads `cfg_rdata` with the register at the read position, zero-extended to DATA_W. It sets `cfg_rd_valid` to 1. It advances the read position in the same cyclic order. The write position is not affected.
- R8: An `rclk` edge without that full condition does three things. It sets `cfg_rd_valid` to 0, keeps `cfg_rdata`, and keeps the read position. The full condition is missing when only one read enable is low, or when `offset_sel_n`=1.
- R9: Outside programmable mode, offset writes and offset reads are ignored. The offsets stay at 7 and `cfg_rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both clocks |
| offset_sel_n | input | 1 | Low selects offset access; sampled at reset to pick the mode |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en0_n | input | 1 | First active-low read enable |
| rd_en1_n | input | 1 | Second active-low read enable |
| din | input | DATA_W | Shared input data bus |
| prog_mode | output | 1 | 1 when programmable mode was chosen at reset |
| fifo_wr | output | 1 | Normal FIFO write request |
| cfg_rd_valid | output | 1 | 1 for the cycle after an offset readback |
| cfg_rdata | output | DATA_W | Offset readback data |
| empty_ofs | output | OFS_W | Empty-side threshold n |
| full_ofs | output | OFS_W | Full-side threshold m |

## Verification
The bench builds the block with its default parameters: a depth of 16384, a 9-bit bus and an 8-bit low part. That leaves six high bits per offset. Writing 0x1FF into a high slot therefore shows that bits above the high part are dropped, and readback of a high slot shows zero-extension. Because there are only four positions, short sequences can reach every slot, the wrap from full-high back to empty-low, and an interrupted sequence on both the write and the read side.

// File: rtl/fifo_ofs_pkg.sv
// Shared types for the threshold offset programmer.
// Assumes a fixed four-slot cyclic access order.
package fifo_ofs_pkg;

    // Slot order matters: bit 1 picks the offset, bit 0 picks low/high part.
    typedef enum logic [1:0] {
        SLOT_EMPTY_LO = 2'd0,
        SLOT_EMPTY_HI = 2'd1,
        SLOT_FULL_LO  = 2'd2,
        SLOT_FULL_HI  = 2'd3
    } ofs_slot_e;

    localparam int unsigned OFS_COUNT = 2;

endpackage

// File: rtl/ofs_slot_ctr.sv
// Cyclic slot position for offset accesses.
// Steps once per qualified access and wraps after the last slot.
// Assumes step is already qualified by mode and select.
module ofs_slot_ctr
    import fifo_ofs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    output ofs_slot_e slot
);

    // Advance the position on every qualified access; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= SLOT_EMPTY_LO;
        end else if (step) begin
            slot <= ofs_slot_e'(slot + 2'd1);
        end
    end

    // R3: each access moves the position to the next slot, with wrap.
    a_r3_slot_advances: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> slot == ofs_slot_e'($past(slot) + 2'd1));

    // R6: position is remembered while no access happens.
    a_r6_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(slot));

endmodule

// File: rtl/ofs_reg_bank.sv
// Four offset part registers, written on the write clock.
// One generate lane per offset holds its low part and its high part.
// Assumes wr_fire is already qualified by mode, select and enable.
module ofs_reg_bank
    import fifo_ofs_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int LO_W    = 8,
    parameter int HI_W    = 6,
    parameter int RST_OFS = 7,
    localparam int OFS_W  = LO_W + HI_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_fire,
    input  ofs_slot_e                         slot,
    input  logic [DATA_W-1:0]                 din,
    output logic [OFS_COUNT-1:0][OFS_W-1:0]   ofs_q
);

    for (genvar g = 0; g < OFS_COUNT; g++) begin : g_ofs
        logic [LO_W-1:0] lo_q;
        logic [HI_W-1:0] hi_q;
        logic            lo_hit;
        logic            hi_hit;

        // Decode which part of this offset the current slot addresses.
        always_comb begin
            lo_hit = wr_fire && (slot[1] == 1'(g)) && !slot[0];
            hi_hit = wr_fire && (slot[1] == 1'(g)) &&  slot[0];
        end

        // Load the low part from the bus, or its reset value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= LO_W'(RST_OFS);
            end else if (lo_hit) begin
                lo_q <= din[LO_W-1:0];
            end
        end

        // Load the high part from the low bus bits, or clear it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (hi_hit) begin
                hi_q <= din[HI_W-1:0];
            end
        end

        assign ofs_q[g] = {hi_q, lo_q};
    end

    // R4: offsets stay put on cycles without a qualified write.
    a_r4_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(ofs_q));

    // R3: a write at the empty-low slot lands in the empty low bits.
    a_r3_empty_lo_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && slot == SLOT_EMPTY_LO) |=> ofs_q[0][LO_W-1:0] == $past(din[LO_W-1:0]));

endmodule

// File: rtl/ofs_readback.sv
// Offset readback on the read clock.
// Presents the addressed register part zero-extended to the bus width.
// Assumes the offsets are quasi-static relative to the read clock.
module ofs_readback
    import fifo_ofs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int LO_W   = 8,
    parameter int HI_W   = 6,
    localparam int OFS_W = LO_W + HI_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_fire,
    input  ofs_slot_e                        slot,
    input  logic [OFS_COUNT-1:0][OFS_W-1:0]  ofs_q,
    output logic                             rd_valid,
    output logic [DATA_W-1:0]                rd_data
);

    logic [DATA_W-1:0] sel_word;
    logic [OFS_W-1:0]  sel_ofs;

    // Pick the addressed offset part and widen it to the bus.
    always_comb begin
        sel_ofs  = ofs_q[slot[1]];
        sel_word = '0;
        if (slot[0]) begin
            sel_word[HI_W-1:0] = sel_ofs[OFS_W-1:LO_W];
        end else begin
            sel_word[LO_W-1:0] = sel_ofs[LO_W-1:0];
        end
    end

    // Register the readback word and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) begin
                rd_data <= sel_word;
            end
        end
    end

    // R7: a qualified read raises valid on the next edge.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rd_valid);

    // R8: without a qualified read, valid drops and data holds.
    a_r8_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> (!rd_valid && $stable(rd_data)));

endmodule

// File: rtl/fifo_ofs_prog.sv
// Threshold offset programmer top level.
// Latches the mode at reset, qualifies offset accesses, keeps separate
// write and read slot positions, and exports both offsets.
// Assumes offsets are reprogrammed only while the FIFO is idle, and that
// offset writes and offset reads are never requested together.
module fifo_ofs_prog
    import fifo_ofs_pkg::*;
#(
    parameter int DEPTH   = 16384,
    parameter int DATA_W  = 9,
    parameter int LO_W    = 8,
    parameter int RST_OFS = 7,
    localparam int OFS_W  = $clog2(DEPTH),
    localparam int HI_W   = OFS_W - LO_W
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              offset_sel_n,
    input  logic              wr_en_n,
    input  logic              rd_en0_n,
    input  logic              rd_en1_n,
    input  logic [DATA_W-1:0] din,
    output logic              prog_mode,
    output logic              fifo_wr,
    output logic              cfg_rd_valid,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);

    logic                            prog_q;
    logic                            wr_fire;
    logic                            rd_fire;
    ofs_slot_e                       wr_slot;
    ofs_slot_e                       rd_slot;
    logic [OFS_COUNT-1:0][OFS_W-1:0] ofs_q;

    // Capture the mode from the select input while reset is held.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            prog_q <= ~offset_sel_n;
        end
    end

    // Qualify offset accesses and the pass-through FIFO write.
    always_comb begin
        wr_fire = prog_q && !offset_sel_n && !wr_en_n;
        rd_fire = prog_q && !offset_sel_n && !rd_en0_n && !rd_en1_n;
        fifo_wr = offset_sel_n && !wr_en_n;
    end

    ofs_slot_ctr u_wr_slot (
        .clk   (wclk),
        .rst_n (rst_n),
        .step  (wr_fire),
        .slot  (wr_slot)
    );

    ofs_slot_ctr u_rd_slot (
        .clk   (rclk),
        .rst_n (rst_n),
        .step  (rd_fire),
        .slot  (rd_slot)
    );

    ofs_reg_bank #(
        .DATA_W  (DATA_W),
        .LO_W    (LO_W),
        .HI_W    (HI_W),
        .RST_OFS (RST_OFS)
    ) u_bank (
        .clk     (wclk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .slot    (wr_slot),
        .din     (din),
        .ofs_q   (ofs_q)
    );

    ofs_readback #(
        .DATA_W (DATA_W),
        .LO_W   (LO_W),
        .HI_W   (HI_W)
    ) u_rdbk (
        .clk      (rclk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .slot     (rd_slot),
        .ofs_q    (ofs_q),
        .rd_valid (cfg_rd_valid),
        .rd_data  (cfg_rdata)
    );

    assign prog_mode = prog_q;
    assign empty_ofs = ofs_q[0];
    assign full_ofs  = ofs_q[1];

    // R1: the mode never changes outside reset.
    a_r1_mode_held: assert property (@(posedge wclk) disable iff (!rst_n)
        rst_n |=> $stable(prog_mode));

    // R9: without programmable mode the offsets keep their reset value.
    a_r9_unprog_static: assert property (@(posedge wclk) disable iff (!rst_n)
        !prog_mode |=> (empty_ofs == OFS_W'(RST_OFS) && full_ofs == OFS_W'(RST_OFS)));

endmodule

// File: tb/fifo_ofs_prog_tb.sv
module fifo_ofs_prog_tb;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       offset_sel_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       rd_en0_n = 1'b1;
    logic       rd_en1_n = 1'b1;
    logic [8:0] din = '0;
    logic       prog_mode;
    logic       fifo_wr;
    logic       cfg_rd_valid;
    logic [8:0] cfg_rdata;
    logic [13:0] empty_ofs;
    logic [13:0] full_ofs;

    int checks = 0;
    int errors = 0;

    // 250 MHz write clock; read clock same rate, 1 ns later.
    initial forever #2 wclk = ~wclk;
    initial begin
        #1;
        forever #2 rclk = ~rclk;
    end

    fifo_ofs_prog u_dut (
        .wclk         (wclk),
        .rclk         (rclk),
        .rst_n        (rst_n),
        .offset_sel_n (offset_sel_n),
        .wr_en_n      (wr_en_n),
        .rd_en0_n     (rd_en0_n),
        .rd_en1_n     (rd_en1_n),
        .din          (din),
        .prog_mode    (prog_mode),
        .fifo_wr      (fifo_wr),
        .cfg_rd_valid (cfg_rd_valid),
        .cfg_rdata    (cfg_rdata),
        .empty_ofs    (empty_ofs),
        .full_ofs     (full_ofs)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        sel_n;
        logic        wr_n;
        logic        rd0_n;
        logic        rd1_n;
        logic [8:0]  din;
        logic [13:0] exp_empty;
        logic [13:0] exp_full;
        logic        exp_valid;
        logic [8:0]  exp_rdata;
        logic        exp_fwr;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0A5, 14'h00A5, 14'h0007, 1'b0, 9'h000, 1'b0}, // R3 empty-low
        '{8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 9'h1FF, 14'h3FA5, 14'h0007, 1'b0, 9'h000, 1'b0}, // R3 empty-high truncated
        '{8'd4, 1'b0, 1'b1, 1'b1, 1'b1, 9'h055, 14'h3FA5, 14'h0007, 1'b0, 9'h000, 1'b0}, // R4 no-op
        '{8'd5, 1'b1, 1'b0, 1'b1, 1'b1, 9'h033, 14'h3FA5, 14'h0007, 1'b0, 9'h000, 1'b1}, // R5 FIFO write
        '{8'd6, 1'b0, 1'b0, 1'b1, 1'b1, 9'h012, 14'h3FA5, 14'h0012, 1'b0, 9'h000, 1'b0}, // R6 resumes at full-low
        '{8'd6, 1'b1, 1'b1, 1'b1, 1'b1, 9'h000, 14'h3FA5, 14'h0012, 1'b0, 9'h000, 1'b0}, // R6 idle gap
        '{8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 9'h005, 14'h3FA5, 14'h0512, 1'b0, 9'h000, 1'b0}, // R3 full-high
        '{8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0C3, 14'h3FC3, 14'h0512, 1'b0, 9'h000, 1'b0}, // R3 wrap to empty-low
        '{8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 14'h3FC3, 14'h0512, 1'b1, 9'h0C3, 1'b0}, // R7 read empty-low
        '{8'd8, 1'b0, 1'b1, 1'b0, 1'b1, 9'h000, 14'h3FC3, 14'h0512, 1'b0, 9'h0C3, 1'b0}, // R8 one enable only
        '{8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 14'h3FC3, 14'h0512, 1'b1, 9'h03F, 1'b0}, // R7 read empty-high
        '{8'd8, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000, 14'h3FC3, 14'h0512, 1'b0, 9'h03F, 1'b0}, // R8 select high
        '{8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 14'h3FC3, 14'h0512, 1'b1, 9'h012, 1'b0}, // R7 read full-low
        '{8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 14'h3FC3, 14'h0512, 1'b1, 9'h005, 1'b0}, // R7 read full-high
        '{8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 14'h3FC3, 14'h0512, 1'b1, 9'h0C3, 1'b0}, // R7 read wraps
        '{8'd7, 1'b0, 1'b0, 1'b1, 1'b1, 9'h000, 14'h00C3, 14'h0512, 1'b0, 9'h0C3, 1'b0}  // R7 write slot untouched by reads
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle: inputs set after the write-clock fall, both clocks
    // rise once, outputs are then sampled at the next write-clock fall.
    task automatic cycle(input logic s, input logic w, input logic r0,
                         input logic r1, input logic [8:0] d);
        offset_sel_n = s;
        wr_en_n      = w;
        rd_en0_n     = r0;
        rd_en1_n     = r1;
        din          = d;
        @(negedge wclk);
    endtask

    task automatic do_reset(input logic sel);
        rst_n = 1'b0;
        cycle(sel, 1'b1, 1'b1, 1'b1, 9'h000);
        cycle(sel, 1'b1, 1'b1, 1'b1, 9'h000);
        rst_n = 1'b1;
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge wclk);
        do_reset(1'b0);
        check("R1", "prog_mode", 32'(prog_mode), 32'd1);
        check("R2", "empty_ofs", 32'(empty_ofs), 32'h7);
        check("R2", "full_ofs", 32'(full_ofs), 32'h7);
        check("R2", "cfg_rd_valid", 32'(cfg_rd_valid), 32'd0);
        check("R2", "cfg_rdata", 32'(cfg_rdata), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            cycle(VEC[i].sel_n, VEC[i].wr_n, VEC[i].rd0_n, VEC[i].rd1_n, VEC[i].din);
            check(tag, $sformatf("vec%0d empty_ofs", i), 32'(empty_ofs), 32'(VEC[i].exp_empty));
            check(tag, $sformatf("vec%0d full_ofs", i), 32'(full_ofs), 32'(VEC[i].exp_full));
            check(tag, $sformatf("vec%0d cfg_rd_valid", i), 32'(cfg_rd_valid), 32'(VEC[i].exp_valid));
            check(tag, $sformatf("vec%0d cfg_rdata", i), 32'(cfg_rdata), 32'(VEC[i].exp_rdata));
            check(tag, $sformatf("vec%0d fifo_wr", i), 32'(fifo_wr), 32'(VEC[i].exp_fwr));
        end

        // R2: read position cleared by reset, first read gives empty-low 7.
        do_reset(1'b0);
        check("R2", "offsets restored", 32'({empty_ofs, full_ofs}), 32'({14'h7, 14'h7}));
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        check("R2", "first read after reset", 32'(cfg_rdata), 32'h007);
        check("R7", "read valid", 32'(cfg_rd_valid), 32'd1);

        // R2: write position cleared by reset after a partial sequence.
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 9'h011);
        do_reset(1'b0);
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 9'h022);
        check("R2", "write restarts at empty-low", 32'(empty_ofs), 32'h0022);

        // R1/R9: non-programmable mode ignores offset traffic.
        do_reset(1'b1);
        check("R1", "prog_mode off", 32'(prog_mode), 32'd0);
        check("R2", "empty after unprog reset", 32'(empty_ofs), 32'h7);
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 9'h044);
        check("R9", "offset write ignored", 32'(empty_ofs), 32'h7);
        check("R9", "full unchanged", 32'(full_ofs), 32'h7);
        check("R5", "no FIFO write with select low", 32'(fifo_wr), 32'd0);
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        check("R9", "offset read ignored", 32'(cfg_rd_valid), 32'd0);
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 9'h066);
        check("R5", "FIFO write in unprog mode", 32'(fifo_wr), 32'd1);
        check("R5", "offsets untouched", 32'(empty_ofs), 32'h7);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule